// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block makes the first decision about every virtual address a processor issues. The decision comes before any page-table lookup. There are three possible routes. If translation is switched off, the address passes through untouched with full rights. If the access comes from supervisor mode and its segment has been enabled for direct mapping, the upper address nibble is replaced by a base nibble taken from one of two banked kernel-base words. Otherwise the request is handed on to a page lookup unit, and the block names which unit: the instruction unit for execute accesses, the data unit for reads and writes.

The block is combinational from request to result, with one register stage at the output. A request presented with `req_valid` in one cycle therefore produces its result, marked by `rsp_valid`, in the next cycle. When no request is presented, the output fields keep their last values.

Top module: `seg_xlate_front`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_valid`, `rsp_paddr`, `rsp_perm`, `rsp_need_walk` and `rsp_to_instr` are all zero.
- R2: When both bits of `xlate_en_bits` are zero, a request yields `rsp_paddr` equal to the virtual address, `rsp_perm` = 3'b111 and `rsp_need_walk` = 0. This holds regardless of mode, segment mask or access kind.
- R3: Translation counts as enabled when either bit of `xlate_en_bits` is set (values 2'b01, 2'b10 and 2'b11 all behave the same).
- R4: With translation enabled, a supervisor request (`req_user` = 0) whose segment `req_vaddr[31:28]` has its bit set in `seg_direct_mask` is direct-mapped. It yields `rsp_paddr` = {base nibble, `req_vaddr[27:0]`}, `rsp_perm` = 3'b111 and `rsp_need_walk` = 0.
- R5: The base nibble for a segment s from 0 to 7 is `kbase_low[4*s+3:4*s]`. For s from 8 to 15 it is `kbase_high[4*(s-8)+3:4*(s-8)]`.
- R6: With translation enabled, a user request (`req_user` = 1) always needs a page lookup, even if its segment's mask bit is set. The result is `rsp_need_walk` = 1, `rsp_perm` = 3'b000 and `rsp_paddr` equal to the virtual address.
- R7: With translation enabled, a supervisor request whose segment mask bit is clear also gives `rsp_need_walk` = 1, `rsp_perm` = 3'b000 and `rsp_paddr` equal to the virtual address.
- R8: `rsp_to_instr` is 1 exactly when `req_kind` = 2'b10 (execute). Read (2'b00), write (2'b01) and the spare code 2'b11 give 0, which selects the data unit.
- R9: `rsp_valid` is high in exactly the cycles after those with `req_valid` high. After a cycle without a request, the output fields are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_kind | input | 2 | 00 read, 01 write, 10 execute, 11 treated as read |
| xlate_en_bits | input | 2 | The two enable bits of the global configuration word |
| seg_direct_mask | input | 16 | Bit s set enables direct mapping of segment s |
| kbase_low | input | 32 | Base nibbles for segments 0 to 7 |
| kbase_high | input | 32 | Base nibbles for segments 8 to 15 |
| rsp_valid | output | 1 | Result valid (one cycle after request) |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights {exec, write, read} |
| rsp_need_walk | output | 1 | Page lookup path required |
| rsp_to_instr | output | 1 | 1 = instruction lookup unit, 0 = data unit |

## Verification
Two functions can apply to the same request. A set segment-mask bit can coincide with a disabled enable field, where pass-through must win. A set mask bit can also coincide with a user-mode request, where the page path must win over direct mapping. The sweep covers both cases. It crosses every segment with both modes, all four enable codes, all four access kinds and two complementary masks. Each registered result is compared against an arithmetic model in the bench, so a wrong priority shows up as a wrong address, wrong rights or a wrong walk flag.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_SPARE = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    RT_PASS = 2'b00,
    RT_SEG  = 2'b01,
    RT_WALK = 2'b10
  } route_e;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/xlate_route_dec.sv
module xlate_route_dec
  import xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  localparam int NSEG = 1 << SEG_W
) (
  input  logic [1:0]       en_bits,
  input  logic [SEG_W-1:0] seg_idx,
  input  logic [NSEG-1:0]  seg_mask,
  input  logic             user,
  output route_e           route
);
  logic xlate_on;
  logic seg_direct;

  assign xlate_on   = |en_bits;
  assign seg_direct = seg_mask[seg_idx] & ~user;

  always_comb begin
    if (!xlate_on)       route = RT_PASS;
    else if (seg_direct) route = RT_SEG;
    else                 route = RT_WALK;
  end
endmodule

// File: rtl/xlate_seg_base.sv
module xlate_seg_base #(
  parameter int SEG_W = 4,
  localparam int NSEG = 1 << SEG_W,
  localparam int HALF = NSEG / 2,
  localparam int KB_W = HALF * SEG_W
) (
  input  logic [SEG_W-1:0] seg_idx,
  input  logic [KB_W-1:0]  base_lo,
  input  logic [KB_W-1:0]  base_hi,
  output logic [SEG_W-1:0] base_nib
);
  logic [SEG_W-1:0] nib_tab [NSEG];

  for (genvar s = 0; s < HALF; s++) begin : g_slice
    assign nib_tab[s]        = base_lo[s*SEG_W +: SEG_W];
    assign nib_tab[s + HALF] = base_hi[s*SEG_W +: SEG_W];
  end

  assign base_nib = nib_tab[seg_idx];
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  localparam int NSEG  = 1 << SEG_W,
  localparam int KB_W  = (NSEG / 2) * SEG_W,
  localparam int OFF_W = ADDR_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_user,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        xlate_en_bits,
  input  logic [NSEG-1:0]   seg_direct_mask,
  input  logic [KB_W-1:0]   kbase_low,
  input  logic [KB_W-1:0]   kbase_high,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [2:0]        rsp_perm,
  output logic              rsp_need_walk,
  output logic              rsp_to_instr
);
  logic [SEG_W-1:0]  seg_idx;
  logic [SEG_W-1:0]  base_nib;
  route_e            route;
  logic [ADDR_W-1:0] nxt_paddr;
  logic [2:0]        nxt_perm;
  logic              nxt_walk;
  logic              nxt_instr;

  assign seg_idx = req_vaddr[ADDR_W-1 -: SEG_W];

  xlate_route_dec #(.SEG_W(SEG_W)) u_route (
    .en_bits  (xlate_en_bits),
    .seg_idx  (seg_idx),
    .seg_mask (seg_direct_mask),
    .user     (req_user),
    .route    (route)
  );

  xlate_seg_base #(.SEG_W(SEG_W)) u_base (
    .seg_idx  (seg_idx),
    .base_lo  (kbase_low),
    .base_hi  (kbase_high),
    .base_nib (base_nib)
  );

  always_comb begin
    nxt_instr = (acc_kind_e'(req_kind) == ACC_EXEC);
    unique case (route)
      RT_SEG: begin
        nxt_paddr = {base_nib, req_vaddr[OFF_W-1:0]};
        nxt_perm  = PERM_ALL;
        nxt_walk  = 1'b0;
      end
      RT_WALK: begin
        nxt_paddr = req_vaddr;
        nxt_perm  = PERM_NONE;
        nxt_walk  = 1'b1;
      end
      default: begin
        nxt_paddr = req_vaddr;
        nxt_perm  = PERM_ALL;
        nxt_walk  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_perm      <= '0;
      rsp_need_walk <= 1'b0;
      rsp_to_instr  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr     <= nxt_paddr;
        rsp_perm      <= nxt_perm;
        rsp_need_walk <= nxt_walk;
        rsp_to_instr  <= nxt_instr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_front_chk.sv
module seg_xlate_front_chk #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  localparam int NSEG  = 1 << SEG_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              req_user,
  input logic [1:0]        req_kind,
  input logic [1:0]        xlate_en_bits,
  input logic [NSEG-1:0]   seg_direct_mask,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_perm,
  input logic              rsp_need_walk,
  input logic              rsp_to_instr
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_perm)));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlate_en_bits == 2'b00) |=>
      (rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b111 && !rsp_need_walk));

  assert_user_walks_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlate_en_bits != 2'b00 && req_user) |=>
      (rsp_need_walk && rsp_perm == 3'b000));

  assert_unit_select_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_to_instr == ($past(req_kind) == 2'b10)));

  assert_direct_low_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlate_en_bits != 2'b00 && !req_user &&
     seg_direct_mask[req_vaddr[ADDR_W-1 -: SEG_W]]) |=>
      (rsp_paddr[ADDR_W-SEG_W-1:0] == $past(req_vaddr[ADDR_W-SEG_W-1:0]) && !rsp_need_walk));
endmodule

bind seg_xlate_front seg_xlate_front_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_vaddr       (req_vaddr),
  .req_user        (req_user),
  .req_kind        (req_kind),
  .xlate_en_bits   (xlate_en_bits),
  .seg_direct_mask (seg_direct_mask),
  .rsp_valid       (rsp_valid),
  .rsp_paddr       (rsp_paddr),
  .rsp_perm        (rsp_perm),
  .rsp_need_walk   (rsp_need_walk),
  .rsp_to_instr    (rsp_to_instr)
);

// File: tb/seg_xlate_front_test.sv
`timescale 1ns/1ps
module seg_xlate_front_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_user;
  logic [1:0]  req_kind;
  logic [1:0]  xlate_en_bits;
  logic [15:0] seg_direct_mask;
  logic [31:0] kbase_low;
  logic [31:0] kbase_high;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        rsp_need_walk;
  logic        rsp_to_instr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seg_xlate_front uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_user(req_user), .req_kind(req_kind), .xlate_en_bits(xlate_en_bits),
    .seg_direct_mask(seg_direct_mask), .kbase_low(kbase_low), .kbase_high(kbase_high),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .rsp_need_walk(rsp_need_walk), .rsp_to_instr(rsp_to_instr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic one_req(input logic [31:0] va, input bit usr, input logic [1:0] kind,
                         input logic [1:0] en, input logic [15:0] mask);
    logic [31:0] e_pa;
    logic [2:0]  e_perm;
    bit          e_walk;
    logic [3:0]  seg;
    logic [3:0]  nib;
    string       tag;
    seg = va[31:28];
    nib = (seg < 8) ? 4'((kbase_low >> (4 * seg)) & 32'hF)
                    : 4'((kbase_high >> (4 * (seg - 8))) & 32'hF);
    if (en == 2'b00) begin
      e_pa = va; e_perm = 3'b111; e_walk = 1'b0; tag = "R2";
    end else if (!usr && mask[seg]) begin
      e_pa = {nib, va[27:0]}; e_perm = 3'b111; e_walk = 1'b0; tag = "R4_R5_R3";
    end else begin
      e_pa = va; e_perm = 3'b000; e_walk = 1'b1; tag = usr ? "R6_R3" : "R7_R3";
    end
    req_valid = 1'b1; req_vaddr = va; req_user = usr; req_kind = kind;
    xlate_en_bits = en; seg_direct_mask = mask;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R9 valid", 32'(rsp_valid), 32'd1);
    check(rsp_paddr == e_pa, {tag, " paddr"}, rsp_paddr, e_pa);
    check(rsp_perm == e_perm, {tag, " perm"}, 32'(rsp_perm), 32'(e_perm));
    check(rsp_need_walk == e_walk, {tag, " walk"}, 32'(rsp_need_walk), 32'(e_walk));
    check(rsp_to_instr == (kind == 2'b10), "R8 unit", 32'(rsp_to_instr), 32'(kind == 2'b10));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_user = 1'b0; req_kind = 2'b00;
    xlate_en_bits = 2'b00; seg_direct_mask = '0;
    kbase_low = 32'h1357_9BDF; kbase_high = 32'h2468_ACE0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 valid", 32'(rsp_valid), 32'd0);
    check(rsp_paddr == 32'd0, "R1 paddr", rsp_paddr, 32'd0);
    check({rsp_perm, rsp_need_walk, rsp_to_instr} == 5'd0, "R1 fields",
          32'({rsp_perm, rsp_need_walk, rsp_to_instr}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 after release", 32'(rsp_valid), 32'd0);

    for (int b = 0; b < 2; b++) begin
      if (b == 1) begin kbase_low = 32'hECA8_6420; kbase_high = 32'hFDB9_7531; end
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 16; s++) begin
          for (int e = 0; e < 4; e++) begin
            for (int u = 0; u < 2; u++) begin
              for (int k = 0; k < 4; k++) begin
                logic [27:0] low;
                low = 28'h9E3_779B ^ 28'(s * 28'h012_3457 + k * 28'h0F0_0F01 + e * 28'h7);
                one_req({4'(s), low}, u[0], 2'(k), 2'(e), m == 0 ? 16'hA5C3 : 16'h5A3C);
              end
            end
          end
        end
      end
    end

    held = rsp_paddr;
    req_valid = 1'b0; req_vaddr = 32'hDEAD_BEEF; req_user = 1'b1; xlate_en_bits = 2'b11;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 idle valid", 32'(rsp_valid), 32'd0);
    check(rsp_paddr == held, "R9 idle hold", rsp_paddr, held);
    @(negedge clk);
    check(rsp_paddr == held, "R9 idle hold 2", rsp_paddr, held);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule